// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block is an I2C-compatible slave that configures a receiver through the bus. It holds a small bank of 8-bit control registers and returns a 4-bit status field. SCL and SDA are sampled in the system clock domain. Each line passes through a synchronizer and a glitch filter before START, STOP and clock edges are detected. The slave drives SDA only through an open-drain enable (`sda_oe` high pulls the line low).

Two strap pins choose the slave address. A write transfer carries a register index and then data bytes, and these go to successive registers. A read transfer ignores the index: it returns the status byte first and then zero bytes. The register contents appear as one flat parallel output, and the status bits come in as parallel inputs.

Top module: `ctrl_i2c_slave`

## Requirements
- R1: `addr_sel` = {AS1,AS0} selects the write/read address bytes: 01 gives 0xC2/0xC3, 10 gives 0xC4/0xC5 and 11 gives 0xC6/0xC7. With 00 the slave answers no address. If an address byte does not match, SDA is left released and no register changes.
- R2: Bytes move MSB first. After every byte the slave receives in a matched write (the address, the index and each data byte), it pulls SDA low for the ninth clock.
- R3: In a write, the first byte after the address is the starting register index. Each data byte goes to the current index, and the index then increments by one. It also increments when the byte was discarded.
- R4: A read returns {4'b0, status_i} as its first byte, then 0x00 for every later byte. In status_i, bit 3 is the RF gain-control engaged flag, bit 2 is overcurrent, bit 1 is antenna-current detect and bit 0 is PLL lock. The status is captured when the read address byte completes. The slave keeps sending while the master ACKs, and after a NACK it releases SDA and goes idle.
- R5: `cfg_bank[8*k+7:8*k]` holds register index k, for k = 0..9. After reset it holds 0x56, 0x1E, 0x90, 0x69, 0x60, 0x04, 0x00, 0x00, 0x00, 0x00 for indices 0..9.
- R6: Indices 7 and 8 always read zero. Bits 7:6 of index 9 are always zero. A write to index 10 or above is acknowledged and discarded.
- R7: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. STOP ends the transfer, and bytes clocked afterwards without a START are ignored. A repeated START restarts address matching.
- R8: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored.
- R9: The slave changes `sda_oe` only while the filtered SCL is low, apart from releasing it on START or STOP. It drives SDA only for an ACK or for a 0 data bit.
- R10: With a 50 MHz clock and default parameters, transfers at a fast-mode (about 400 kbit/s) bus rate complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| addr_sel | input | 2 | Address straps {AS1,AS0} |
| status_i | input | 4 | Status flags {agc, overcurrent, antenna, lock} |
| cfg_bank | output | SLOTS*8 | Register contents, index k at bits 8k+7:8k |

## Verification
The bench builds the block with its defaults: two synchronizer stages, a three-clock glitch filter and ten register slots. A three-clock filter lets a 50 MHz bench inject two-clock spikes on SCL and SDA in the middle of a byte. Those spikes would corrupt the byte, or fake a START, if the filter were missing or too short. Ten slots put the masked slots 7, 8 and 9 and the out-of-range index 0x0C within reach of the vector table and of the auto-increment runs. The bus runs at 128 clocks per bit, which is near the fast-mode rate.

// File: rtl/ctrl_i2c_pkg.sv
package ctrl_i2c_pkg;

    localparam int SLOT_COUNT = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_SACK,
        ST_RDATA,
        ST_MACK
    } phase_e;

    // Power-on contents of each register slot
    function automatic logic [7:0] slot_reset(int k);
        case (k)
            0:       return 8'h56;
            1:       return 8'h1E;
            2:       return 8'h90;
            3:       return 8'h69;
            4:       return 8'h60;
            5:       return 8'h04;
            default: return 8'h00;
        endcase
    endfunction

    // Writable bits of each slot; zero means the slot is not stored
    function automatic logic [7:0] slot_keep(int k);
        case (k)
            7, 8:    return 8'h00;
            9:       return 8'h3F;
            default: return 8'hFF;
        endcase
    endfunction

    // Write address byte chosen by the straps (read = this | 1)
    function automatic logic [7:0] write_addr(logic [1:0] sel);
        return {5'b11000, sel, 1'b0};
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int MSB = SYNC_STAGES - 1;
    localparam int CW  = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   filt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[SYNC_STAGES-2:0], line_i};
        if (flt_q.sync[MSB] != flt_q.filt) begin
            if (flt_q.cnt == CW'(FILT_LEN - 1)) begin
                flt_d.filt = flt_q.sync[MSB];
                flt_d.cnt  = '0;
            end else begin
                flt_d.cnt = flt_q.cnt + CW'(1);
            end
        end else begin
            flt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q.sync <= '1;
            flt_q.cnt  <= '0;
            flt_q.filt <= 1'b1;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign line_o = flt_q.filt;

    // R8
    filt_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.filt != $past(flt_q.filt)) |-> ($past(flt_q.sync[MSB]) == flt_q.filt));

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_f;
        prev_d.sda = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    assign rise_o  = scl_f & ~prev_q.scl;
    assign fall_o  = ~scl_f & prev_q.scl;
    assign start_o = scl_f & prev_q.scl & prev_q.sda & ~sda_f;
    assign stop_o  = scl_f & prev_q.scl & ~prev_q.sda & sda_f;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import ctrl_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic [1:0] addr_sel,
    input  logic [3:0] status_i,
    output logic       wr_en_o,
    output logic [7:0] wr_idx_o,
    output logic [7:0] wr_data_o,
    output logic       sda_oe_o
);
    typedef struct packed {
        phase_e     st;
        phase_e     ret;
        logic [3:0] cnt;
        logic [7:0] sr;
        logic [7:0] ptr;
        logic [7:0] tx;
        logic       mack;
        logic       drive;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic hit_wr, hit_rd, wr_en;

    assign hit_wr = (|addr_sel) && (fsm_q.sr == write_addr(addr_sel));
    assign hit_rd = (|addr_sel) && (fsm_q.sr == (write_addr(addr_sel) | 8'h01));

    always_comb begin
        fsm_d = fsm_q;
        wr_en = 1'b0;
        if (stop_i) begin
            fsm_d.st    = ST_IDLE;
            fsm_d.drive = 1'b0;
        end else if (start_i) begin
            fsm_d.st    = ST_ADDR;
            fsm_d.cnt   = '0;
            fsm_d.drive = 1'b0;
        end else begin
            case (fsm_q.st)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (rise_i) begin
                        fsm_d.sr  = {fsm_q.sr[6:0], sda_f};
                        fsm_d.cnt = fsm_q.cnt + 4'd1;
                    end else if (fall_i && fsm_q.cnt == 4'd8) begin
                        fsm_d.cnt   = '0;
                        fsm_d.st    = ST_SACK;
                        fsm_d.drive = 1'b1;
                        if (fsm_q.st == ST_ADDR) begin
                            if (hit_wr) begin
                                fsm_d.ret = ST_CMD;
                            end else if (hit_rd) begin
                                fsm_d.ret = ST_RDATA;
                                fsm_d.tx  = {4'b0000, status_i};
                            end else begin
                                fsm_d.st    = ST_IDLE;
                                fsm_d.drive = 1'b0;
                            end
                        end else if (fsm_q.st == ST_CMD) begin
                            fsm_d.ptr = fsm_q.sr;
                            fsm_d.ret = ST_WDATA;
                        end else begin
                            wr_en     = 1'b1;
                            fsm_d.ptr = fsm_q.ptr + 8'd1;
                            fsm_d.ret = ST_WDATA;
                        end
                    end
                end
                ST_SACK: begin
                    if (fall_i) begin
                        fsm_d.st    = fsm_q.ret;
                        fsm_d.cnt   = '0;
                        fsm_d.drive = (fsm_q.ret == ST_RDATA) ? ~fsm_q.tx[7] : 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (fall_i) begin
                        if (fsm_q.cnt == 4'd7) begin
                            fsm_d.st    = ST_MACK;
                            fsm_d.cnt   = '0;
                            fsm_d.drive = 1'b0;
                        end else begin
                            fsm_d.tx    = {fsm_q.tx[6:0], 1'b0};
                            fsm_d.cnt   = fsm_q.cnt + 4'd1;
                            fsm_d.drive = ~fsm_q.tx[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (rise_i) begin
                        fsm_d.mack = ~sda_f;
                    end else if (fall_i) begin
                        if (fsm_q.mack) begin
                            fsm_d.st    = ST_RDATA;
                            fsm_d.tx    = 8'h00;
                            fsm_d.cnt   = '0;
                            fsm_d.drive = 1'b1;
                        end else begin
                            fsm_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, ret: ST_IDLE, cnt: 4'd0, sr: 8'h00,
                       ptr: 8'h00, tx: 8'h00, mack: 1'b0, drive: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign wr_en_o   = wr_en;
    assign wr_idx_o  = fsm_q.ptr;
    assign wr_data_o = fsm_q.sr;
    assign sda_oe_o  = fsm_q.drive;

    // R9
    sda_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.drive != $past(fsm_q.drive)) |->
            (!$past(scl_f) || $past(start_i) || $past(stop_i)));

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (fsm_q.ptr == $past(fsm_q.ptr) + 8'd1));

    // R1
    foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_ADDR && fall_i && fsm_q.cnt == 4'd8 && !hit_wr && !hit_rd
         && !start_i && !stop_i) |=> (!fsm_q.drive && fsm_q.st == ST_IDLE));

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import ctrl_i2c_pkg::*;
#(
    parameter int SLOTS = SLOT_COUNT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_idx,
    input  logic [7:0]         wr_data,
    output logic [SLOTS*8-1:0] bank_o
);
    localparam logic [7:0] LIMIT = 8'(SLOTS);

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        localparam logic [7:0] KEEP = slot_keep(k);
        localparam logic [7:0] RST  = slot_reset(k);
        localparam logic [7:0] IDX  = 8'(k);
        if (KEEP == 8'h00) begin : g_void
            assign bank_o[k*8 +: 8] = 8'h00;
        end else begin : g_live
            logic [7:0] slot_d, slot_q;
            always_comb begin
                slot_d = slot_q;
                if (wr_en && wr_idx == IDX) slot_d = wr_data & KEEP;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) slot_q <= RST;
                else        slot_q <= slot_d;
            end
            assign bank_o[k*8 +: 8] = slot_q;
        end
    end

    // R6
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx < LIMIT) |=> $stable(bank_o));

endmodule

// File: rtl/ctrl_i2c_slave.sv
module ctrl_i2c_slave
    import ctrl_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    parameter int SLOTS       = SLOT_COUNT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [1:0]         addr_sel,
    input  logic [3:0]         status_i,
    output logic [SLOTS*8-1:0] cfg_bank
);
    logic [1:0] raw_lines, clean_lines;
    logic       start_ev, stop_ev, rise_ev, fall_ev;
    logic       wr_en;
    logic [7:0] wr_idx, wr_data;

    assign raw_lines = {scl_i, sda_i};

    for (genvar i = 0; i < 2; i++) begin : g_line
        i2c_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) u_filter (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[i]),
            .line_o (clean_lines[i])
        );
    end

    i2c_bus_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (clean_lines[1]),
        .sda_f   (clean_lines[0]),
        .start_o (start_ev),
        .stop_o  (stop_ev),
        .rise_o  (rise_ev),
        .fall_o  (fall_ev)
    );

    i2c_target_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (clean_lines[1]),
        .sda_f     (clean_lines[0]),
        .start_i   (start_ev),
        .stop_i    (stop_ev),
        .rise_i    (rise_ev),
        .fall_i    (fall_ev),
        .addr_sel  (addr_sel),
        .status_i  (status_i),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data),
        .sda_oe_o  (sda_oe)
    );

    cfg_reg_bank #(
        .SLOTS (SLOTS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .bank_o  (cfg_bank)
    );

endmodule

// File: tb/ctrl_i2c_slave_bench.sv
module ctrl_i2c_slave_bench;
    localparam int QTR   = 32;
    localparam int SLOTS = 10;

    // {sel[25:24], idx[23:16], data[15:8], expected slot value[7:0]}
    localparam logic [25:0] VEC [8] = '{
        {2'b01, 8'h00, 8'hA5, 8'hA5},
        {2'b10, 8'h03, 8'h3C, 8'h3C},
        {2'b11, 8'h05, 8'hFF, 8'hFF},
        {2'b01, 8'h09, 8'hFF, 8'h3F},
        {2'b10, 8'h07, 8'hAA, 8'h00},
        {2'b11, 8'h0C, 8'h77, 8'h00},
        {2'b01, 8'h06, 8'h81, 8'h81},
        {2'b10, 8'h04, 8'h12, 8'h12}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               m_scl = 1'b1;
    logic               m_sda_low = 1'b0;
    logic [1:0]         sel = 2'b01;
    logic [3:0]         stat = 4'b0000;
    logic               sda_oe;
    logic [SLOTS*8-1:0] bank;
    logic               sda_line;
    logic [7:0]         mdl [SLOTS];
    int                 n_tests = 0;
    int                 n_fail = 0;

    assign sda_line = !(m_sda_low || sda_oe);

    ctrl_i2c_slave u_ctrl_i2c_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .addr_sel (sel),
        .status_i (stat),
        .cfg_bank (bank)
    );

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [79:0] mdl_flat();
        logic [79:0] f;
        for (int k = 0; k < SLOTS; k++) f[k*8 +: 8] = mdl[k];
        return f;
    endfunction

    function automatic void mdl_write(input logic [7:0] idx, input logic [7:0] val);
        if (idx < 8'd10) begin
            if (idx == 8'd7 || idx == 8'd8) mdl[idx] = 8'h00;
            else if (idx == 8'd9)           mdl[idx] = val & 8'h3F;
            else                            mdl[idx] = val;
        end
    endfunction

    task automatic bus_start();
        m_sda_low = 1'b0; wq(QTR);
        m_scl = 1'b1;     wq(QTR);
        m_sda_low = 1'b1; wq(QTR);
        m_scl = 1'b0;     wq(QTR);
    endtask

    task automatic bus_stop();
        m_scl = 1'b0;
        m_sda_low = 1'b1; wq(QTR);
        m_scl = 1'b1;     wq(QTR);
        m_sda_low = 1'b0; wq(2*QTR);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !b[i];
            wq(QTR/2);
            if (glitch && i == 4) begin
                m_scl = 1'b1; wq(2); m_scl = 1'b0;
            end
            wq(QTR/2);
            m_scl = 1'b1;
            wq(QTR);
            if (glitch && i == 3 && b[3]) begin
                m_sda_low = 1'b1; wq(2); m_sda_low = 1'b0;
            end
            wq(QTR);
            m_scl = 1'b0;
            wq(QTR);
        end
        m_sda_low = 1'b0; wq(QTR);
        m_scl = 1'b1;     wq(QTR);
        acked = !sda_line; wq(QTR);
        m_scl = 1'b0;     wq(QTR);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b, output bit steady);
        logic s0, s1;
        m_sda_low = 1'b0;
        steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(QTR);
            m_scl = 1'b1;
            wq(QTR/2); s0 = sda_line;
            wq(QTR);   s1 = sda_line;
            wq(QTR/2);
            m_scl = 1'b0;
            b[i] = s0;
            if (s0 != s1) steady = 1'b0;
        end
        m_sda_low = give_ack; wq(QTR);
        m_scl = 1'b1;         wq(2*QTR);
        m_scl = 1'b0;         wq(QTR);
        m_sda_low = 1'b0;
    endtask

    task automatic write_seq(input logic [1:0] s, input logic [7:0] idx,
                             input logic [7:0] d0, input logic [7:0] d1,
                             input logic [7:0] d2, input logic [7:0] d3, input int n);
        logic [7:0] arr [4];
        bit a;
        arr = '{d0, d1, d2, d3};
        sel = s;
        bus_start();
        send_byte({5'b11000, s, 1'b0}, 1'b0, a);
        chk("R2 ack of address", 80'(a), 80'd1);
        send_byte(idx, 1'b0, a);
        chk("R2 ack of index", 80'(a), 80'd1);
        for (int j = 0; j < n; j++) begin
            send_byte(arr[j], 1'b0, a);
            chk("R2 R6 ack of data", 80'(a), 80'd1);
            mdl_write(idx + 8'(j), arr[j]);
        end
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R10 watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit a, st;
        logic [7:0] rb;

        mdl = '{8'h56, 8'h1E, 8'h90, 8'h69, 8'h60, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00};
        wq(5);
        rst_n = 1'b1;
        wq(10);
        // R5 reset contents and layout
        chk("R5 reset bank", bank, mdl_flat());
        chk("R9 sda released after reset", 80'(sda_oe), 80'd0);

        // Vector walk: single-byte writes under each strap setting (R1, R3, R6, R10)
        for (int v = 0; v < 8; v++) begin
            logic [7:0] vidx;
            vidx = VEC[v][23:16];
            write_seq(VEC[v][25:24], vidx, VEC[v][15:8], 8'h00, 8'h00, 8'h00, 1);
            if (vidx < 8'd10)
                chk("R3 R10 slot after write", 80'(bank[vidx*8 +: 8]), 80'(VEC[v][7:0]));
            chk("R6 whole bank after write", bank, mdl_flat());
        end

        // R3 auto-increment run
        write_seq(2'b11, 8'h01, 8'h11, 8'h22, 8'h33, 8'h00, 3);
        chk("R3 auto-increment run", bank, mdl_flat());
        // R3 pointer advances across unused slots 7 and 8 into slot 9
        write_seq(2'b01, 8'h06, 8'h66, 8'h77, 8'h88, 8'h99, 4);
        chk("R3 R6 run across unused slots", bank, mdl_flat());
        chk("R6 slot 9 masked", 80'(bank[9*8 +: 8]), 80'h19);

        // R1 foreign address and empty strap
        sel = 2'b01;
        bus_start();
        send_byte(8'hC4, 1'b0, a);
        chk("R1 foreign address not acked", 80'(a), 80'd0);
        bus_stop();
        sel = 2'b00;
        bus_start();
        send_byte(8'hC0, 1'b0, a);
        chk("R1 strap 00 answers nothing", 80'(a), 80'd0);
        bus_stop();
        chk("R1 bank unchanged", bank, mdl_flat());

        // R4 read: status then zero
        stat = 4'b1010;
        sel = 2'b10;
        bus_start();
        send_byte(8'hC5, 1'b0, a);
        chk("R4 read address acked", 80'(a), 80'd1);
        recv_byte(1'b1, rb, st);
        chk("R4 status byte", 80'(rb), 80'h0A);
        chk("R9 sda steady while scl high", 80'(st), 80'd1);
        recv_byte(1'b0, rb, st);
        chk("R4 reserved byte", 80'(rb), 80'h00);
        chk("R4 released after nack", 80'(sda_oe), 80'd0);
        bus_stop();

        // R4 three-byte read with the other strap
        stat = 4'b0101;
        sel = 2'b11;
        bus_start();
        send_byte(8'hC7, 1'b0, a);
        chk("R4 read address C7 acked", 80'(a), 80'd1);
        recv_byte(1'b1, rb, st);
        chk("R4 status byte 05", 80'(rb), 80'h05);
        chk("R9 steady bits", 80'(st), 80'd1);
        recv_byte(1'b1, rb, st);
        chk("R4 second byte zero", 80'(rb), 80'h00);
        recv_byte(1'b0, rb, st);
        chk("R4 third byte zero", 80'(rb), 80'h00);
        bus_stop();
        chk("R4 bank untouched by read", bank, mdl_flat());

        // R7 write then repeated START into a read
        stat = 4'b0011;
        sel = 2'b01;
        bus_start();
        send_byte(8'hC2, 1'b0, a);
        send_byte(8'h00, 1'b0, a);
        send_byte(8'h5A, 1'b0, a);
        chk("R7 data acked before restart", 80'(a), 80'd1);
        mdl_write(8'h00, 8'h5A);
        bus_start();
        send_byte(8'hC3, 1'b0, a);
        chk("R7 read acked after restart", 80'(a), 80'd1);
        recv_byte(1'b0, rb, st);
        chk("R7 status after restart", 80'(rb), 80'h03);
        bus_stop();
        chk("R7 write before restart kept", bank, mdl_flat());

        // R7 repeated START with a foreign address drops the transfer
        bus_start();
        send_byte(8'hC2, 1'b0, a);
        send_byte(8'h02, 1'b0, a);
        bus_start();
        send_byte(8'hC4, 1'b0, a);
        chk("R7 foreign restart not acked", 80'(a), 80'd0);
        send_byte(8'hEE, 1'b0, a);
        chk("R7 later byte not acked", 80'(a), 80'd0);
        bus_stop();
        chk("R7 slot 2 unchanged", 80'(bank[2*8 +: 8]), 80'(mdl[2]));

        // R7 bytes after STOP without START are ignored
        send_byte(8'hC2, 1'b0, a);
        chk("R7 byte without start ignored", 80'(a), 80'd0);
        bus_stop();

        // R8 short spikes on SCL and SDA inside a data byte
        sel = 2'b11;
        bus_start();
        send_byte(8'hC6, 1'b0, a);
        send_byte(8'h04, 1'b0, a);
        send_byte(8'h5A, 1'b1, a);
        chk("R8 spiked byte acked", 80'(a), 80'd1);
        bus_stop();
        mdl_write(8'h04, 8'h5A);
        chk("R8 spiked byte stored intact", 80'(bank[4*8 +: 8]), 80'h5A);
        chk("R8 R10 final bank", bank, mdl_flat());

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule